// File: doc/BRIEF.md
# Advisory Non-Fatal Error Logger

This block records what happens when a received transaction-layer packet carries an error, a poisoned packet for example, that is reported as an advisory non-fatal error. Each error arrives as a single-cycle event. The event carries an error-type index and the header captured from the packet. The block looks up the per-type severity and uncorrectable-mask settings, together with the global advisory mask bit and the correctable-reporting enable. From these it decides which of its sticky records to update and whether to ask for a correctable error message.

The block keeps five records: a device-level correctable-detected flag, an advisory status bit, one uncorrectable status bit per error type, a first-error pointer with its valid flag, and a header log. All of them are sticky. Software clears them through write-1-to-clear pulse vectors, and the register decode that produces those pulses sits outside this block. The block has no ready or stall output, so the packet path that carries a poisoned packet onward never waits on it. Events may arrive on every cycle.

Top module: `anfe_logger`

## Requirements
- R1: After reset, every status output, the first-error pointer, its valid flag, the header log and the message request are all zero.
- R2: An in-range event whose severity bit is 0 (non-fatal) sets the correctable-detected flag and the advisory status bit on the next clock edge. This holds whatever the mask and enable settings are.
- R3: Such a non-fatal event sets the uncorrectable status bit of its type only while the advisory mask bit is 0. While the advisory mask bit is 1, the uncorrectable status bits do not change.
- R4: A non-fatal event loads the header into the header log and loads its type into the first-error pointer, and sets the valid flag, only when all three of these hold: the advisory mask bit is 0, the type's uncorrectable mask bit is 0, and the valid flag is 0. In every other case the pointer and the header log keep their values.
- R5: The message request is high for exactly the one cycle after each non-fatal event that arrives with the advisory mask bit at 0 and the reporting enable at 1. Events on consecutive cycles give requests on consecutive cycles. The request is low in every other cycle.
- R6: An event whose severity bit is 1 (fatal) changes no state and raises no message request.
- R7: A 1 in a clear vector clears the matching sticky bit. Bits that are not cleared keep their values.
- R8: Clearing the uncorrectable status bit that the pointer names also clears the valid flag, which allows the next header to be logged. Clearing any other bit leaves the valid flag unchanged.
- R9: When an event sets a bit in the same cycle that a clear vector clears that bit, the bit ends up set. The valid flag is then not released by that clear.
- R10: An event whose type index is NUM_TYPES or greater is ignored completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Single-cycle error event |
| evt_type | input | TYPE_W | Error-type index of the event |
| evt_hdr | input | HDR_W | Header captured from the packet |
| cfg_sev_fatal | input | NUM_TYPES | Per-type severity bit, where 1 means fatal |
| cfg_unc_mask | input | NUM_TYPES | Per-type uncorrectable mask |
| cfg_adv_mask | input | 1 | Advisory bit of the correctable mask |
| cfg_cor_msg_en | input | 1 | Correctable-reporting enable |
| clr_unc_sts | input | NUM_TYPES | Write-1-to-clear pulses for the uncorrectable status bits |
| clr_adv_sts | input | 1 | Write-1-to-clear pulse for the advisory status bit |
| clr_cor_det | input | 1 | Write-1-to-clear pulse for the detected flag |
| cor_det | output | 1 | Correctable-detected flag |
| adv_sts | output | 1 | Advisory non-fatal status bit |
| unc_sts | output | NUM_TYPES | Per-type uncorrectable status bits |
| first_ptr | output | TYPE_W | First-error pointer |
| first_ptr_vld | output | 1 | First-error pointer valid flag |
| hdr_log | output | HDR_W | Logged header |
| cor_msg_req | output | 1 | Correctable message request pulse |

## Verification
The bench builds the block with NUM_TYPES = 5 and HDR_W = 32. This gives a three-bit type index, so the out-of-range indices 5 to 7 can be driven directly. The bench sweeps every type index against every combination of severity, uncorrectable mask, advisory mask and enable, each with the pointer both free and already held. This covers every branch of the logging decision. A long run of random events and clear pulses is checked against a model of the requirements, which brings in same-cycle set-and-clear collisions and pointer release.

// File: rtl/anfe_pkg.sv
// Shared types for the advisory non-fatal error logger.
package anfe_pkg;

    // Actions chosen for one event: record, set status, log header, request message.
    typedef struct packed {
        logic nonfatal;
        logic set_unc;
        logic log_hdr;
        logic send_msg;
    } anfe_act_t;

endpackage

// File: rtl/anfe_qualify.sv
// Decides, combinationally, what an incoming error event is allowed to do.
// Assumes the event is valid for one cycle only and that the configuration
// inputs are stable around it. An index at or above NUM_TYPES gives no action.
module anfe_qualify
    import anfe_pkg::*;
#(
    parameter  int NUM_TYPES = 32,
    localparam int TYPE_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
    input  logic                 evt_valid,
    input  logic [TYPE_W-1:0]    evt_type,
    input  logic [NUM_TYPES-1:0] cfg_sev_fatal,
    input  logic [NUM_TYPES-1:0] cfg_unc_mask,
    input  logic                 cfg_adv_mask,
    input  logic                 cfg_cor_msg_en,
    input  logic                 ptr_held,
    output logic [NUM_TYPES-1:0] type_oh,
    output anfe_act_t            act
);

    localparam logic [TYPE_W:0] TYPE_LIMIT = (TYPE_W + 1)'(NUM_TYPES);

    logic type_in_range;
    logic sev_is_fatal;
    logic type_masked;

    // Decode the index into a one-hot vector, which is empty when the index is out of range.
    always_comb begin
        type_in_range = ({1'b0, evt_type} < TYPE_LIMIT);
        type_oh       = type_in_range ? (NUM_TYPES'(1) << evt_type) : '0;
    end

    // Look up the per-type severity and mask bits through the one-hot vector.
    always_comb begin
        sev_is_fatal = |(cfg_sev_fatal & type_oh);
        type_masked  = |(cfg_unc_mask & type_oh);
    end

    // Build the gating chain from the detected flags down to the message request.
    always_comb begin
        act.nonfatal = evt_valid & type_in_range & ~sev_is_fatal;
        act.set_unc  = act.nonfatal & ~cfg_adv_mask;
        act.log_hdr  = act.set_unc & ~type_masked & ~ptr_held;
        act.send_msg = act.set_unc & cfg_cor_msg_en;
    end

endmodule

// File: rtl/anfe_sticky_bits.sv
// A vector of sticky status bits with write-1-to-clear.
// If a set and a clear reach the same bit in one cycle, the set wins.
module anfe_sticky_bits #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;

        // Hold one bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         bit_q <= 1'b0;
            else if (set_i[i])  bit_q <= 1'b1;
            else if (clr_i[i])  bit_q <= 1'b0;
        end

        assign q_o[i] = bit_q;
    end

endmodule

// File: rtl/anfe_first_log.sv
// Holds the first-error pointer, its valid flag and the header log.
// Assumes log_i is only raised while the valid flag is low. The pointer
// therefore always names an in-range type.
module anfe_first_log #(
    parameter  int NUM_TYPES = 32,
    parameter  int HDR_W     = 128,
    localparam int TYPE_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 log_i,
    input  logic [TYPE_W-1:0]    type_i,
    input  logic [HDR_W-1:0]     hdr_i,
    input  logic [NUM_TYPES-1:0] set_oh_i,
    input  logic [NUM_TYPES-1:0] clr_i,
    output logic [TYPE_W-1:0]    ptr_o,
    output logic                 vld_o,
    output logic [HDR_W-1:0]     hdr_o
);

    logic [NUM_TYPES-1:0] ptr_oh;
    logic                 release_ptr;

    // The held pointer is released when its status bit is cleared and not set again in the same cycle.
    always_comb begin
        ptr_oh      = NUM_TYPES'(1) << ptr_o;
        release_ptr = vld_o & |(ptr_oh & clr_i & ~set_oh_i);
    end

    // Track the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           vld_o <= 1'b0;
        else if (log_i)       vld_o <= 1'b1;
        else if (release_ptr) vld_o <= 1'b0;
    end

    // Capture the pointer and the header on a log event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
            hdr_o <= '0;
        end else if (log_i) begin
            ptr_o <= type_i;
            hdr_o <= hdr_i;
        end
    end

endmodule

// File: rtl/anfe_logger.sv
// Top of the advisory non-fatal error logger. It reports non-fatal errors as
// correctable advisories, keeps the sticky records and requests the messages.
// It has no stall path: an event can be taken on every cycle.
module anfe_logger
    import anfe_pkg::*;
#(
    parameter  int NUM_TYPES = 32,
    parameter  int HDR_W     = 128,
    localparam int TYPE_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [TYPE_W-1:0]    evt_type,
    input  logic [HDR_W-1:0]     evt_hdr,
    input  logic [NUM_TYPES-1:0] cfg_sev_fatal,
    input  logic [NUM_TYPES-1:0] cfg_unc_mask,
    input  logic                 cfg_adv_mask,
    input  logic                 cfg_cor_msg_en,
    input  logic [NUM_TYPES-1:0] clr_unc_sts,
    input  logic                 clr_adv_sts,
    input  logic                 clr_cor_det,
    output logic                 cor_det,
    output logic                 adv_sts,
    output logic [NUM_TYPES-1:0] unc_sts,
    output logic [TYPE_W-1:0]    first_ptr,
    output logic                 first_ptr_vld,
    output logic [HDR_W-1:0]     hdr_log,
    output logic                 cor_msg_req
);

    anfe_act_t            act;
    logic [NUM_TYPES-1:0] type_oh;
    logic [NUM_TYPES-1:0] unc_set_oh;
    logic [1:0]           flag_q;

    anfe_qualify #(.NUM_TYPES(NUM_TYPES)) u_qual (
        .evt_valid      (evt_valid),
        .evt_type       (evt_type),
        .cfg_sev_fatal  (cfg_sev_fatal),
        .cfg_unc_mask   (cfg_unc_mask),
        .cfg_adv_mask   (cfg_adv_mask),
        .cfg_cor_msg_en (cfg_cor_msg_en),
        .ptr_held       (first_ptr_vld),
        .type_oh        (type_oh),
        .act            (act)
    );

    // Select the status bit to set, but only when the advisory is unmasked.
    always_comb unc_set_oh = act.set_unc ? type_oh : '0;

    anfe_sticky_bits #(.W(NUM_TYPES)) u_unc (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (unc_set_oh),
        .clr_i (clr_unc_sts),
        .q_o   (unc_sts)
    );

    anfe_sticky_bits #(.W(2)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({act.nonfatal, act.nonfatal}),
        .clr_i ({clr_cor_det, clr_adv_sts}),
        .q_o   (flag_q)
    );

    assign cor_det = flag_q[1];
    assign adv_sts = flag_q[0];

    anfe_first_log #(.NUM_TYPES(NUM_TYPES), .HDR_W(HDR_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .log_i    (act.log_hdr),
        .type_i   (evt_type),
        .hdr_i    (evt_hdr),
        .set_oh_i (unc_set_oh),
        .clr_i    (clr_unc_sts),
        .ptr_o    (first_ptr),
        .vld_o    (first_ptr_vld),
        .hdr_o    (hdr_log)
    );

    // Register the message request, giving a one-cycle pulse per qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n) cor_msg_req <= 1'b0;
        else        cor_msg_req <= act.send_msg;
    end

endmodule

// File: rtl/anfe_logger_chk.sv
// Checker for anfe_logger. It relates the port inputs to the outputs one cycle later.
module anfe_logger_chk #(
    parameter  int NUM_TYPES = 32,
    parameter  int HDR_W     = 128,
    localparam int TYPE_W    = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_valid,
    input logic [TYPE_W-1:0]    evt_type,
    input logic [HDR_W-1:0]     evt_hdr,
    input logic [NUM_TYPES-1:0] cfg_sev_fatal,
    input logic [NUM_TYPES-1:0] cfg_unc_mask,
    input logic                 cfg_adv_mask,
    input logic                 cfg_cor_msg_en,
    input logic [NUM_TYPES-1:0] clr_unc_sts,
    input logic                 clr_adv_sts,
    input logic                 clr_cor_det,
    input logic                 cor_det,
    input logic                 adv_sts,
    input logic [NUM_TYPES-1:0] unc_sts,
    input logic [TYPE_W-1:0]    first_ptr,
    input logic                 first_ptr_vld,
    input logic [HDR_W-1:0]     hdr_log,
    input logic                 cor_msg_req
);

    localparam logic [TYPE_W:0] LIM = (TYPE_W + 1)'(NUM_TYPES);

    logic [NUM_TYPES-1:0] ev_oh;
    logic [NUM_TYPES-1:0] held_oh;
    logic                 ev_fatal;
    logic                 ev_nf;
    logic                 no_clr;

    always_comb begin
        ev_oh    = ({1'b0, evt_type} < LIM) ? (NUM_TYPES'(1) << evt_type) : '0;
        held_oh  = NUM_TYPES'(1) << first_ptr;
        ev_fatal = evt_valid & |(ev_oh & cfg_sev_fatal);
        ev_nf    = evt_valid & (|ev_oh) & ~|(ev_oh & cfg_sev_fatal);
        no_clr   = ~|clr_unc_sts & ~clr_adv_sts & ~clr_cor_det;
    end

    // R2
    nonfatal_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nf |=> (cor_det && adv_sts));

    // R3
    masked_keeps_unc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nf && cfg_adv_mask && ~|clr_unc_sts) |=> $stable(unc_sts));

    // R4
    held_ptr_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_ptr_vld && ~|(clr_unc_sts & held_oh)) |=>
            (first_ptr_vld && $stable(first_ptr) && $stable(hdr_log)));

    // R5
    msg_on_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nf && !cfg_adv_mask && cfg_cor_msg_en) |=> cor_msg_req);

    // R5
    no_spurious_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_nf && !cfg_adv_mask && cfg_cor_msg_en) |=> !cor_msg_req);

    // R6
    fatal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fatal && no_clr) |=> ($stable(cor_det) && $stable(adv_sts) &&
            $stable(unc_sts) && $stable(first_ptr_vld) && $stable(hdr_log)));

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nf && !cfg_adv_mask && |(clr_unc_sts & ev_oh)) |=> |(unc_sts & $past(ev_oh)));

endmodule

bind anfe_logger anfe_logger_chk #(.NUM_TYPES(NUM_TYPES), .HDR_W(HDR_W)) u_chk (.*);

// File: tb/anfe_logger_test.sv
module anfe_logger_test;

    localparam int NT = 5;
    localparam int HW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic [2:0]    evt_type = '0;
    logic [HW-1:0] evt_hdr = '0;
    logic [NT-1:0] cfg_sev_fatal = '0;
    logic [NT-1:0] cfg_unc_mask = '0;
    logic          cfg_adv_mask = 1'b0;
    logic          cfg_cor_msg_en = 1'b0;
    logic [NT-1:0] clr_unc_sts = '0;
    logic          clr_adv_sts = 1'b0;
    logic          clr_cor_det = 1'b0;
    logic          cor_det, adv_sts, first_ptr_vld, cor_msg_req;
    logic [NT-1:0] unc_sts;
    logic [2:0]    first_ptr;
    logic [HW-1:0] hdr_log;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected state, computed from the requirements.
    logic          m_cor, m_adv, m_vld, m_req;
    logic [NT-1:0] m_unc;
    logic [2:0]    m_ptr;
    logic [HW-1:0] m_hdr;

    always #2 clk = ~clk;

    anfe_logger #(.NUM_TYPES(NT), .HDR_W(HW)) uut (.*);

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        check("R2", {ctx, " cor_det"}, 64'(cor_det), 64'(m_cor));
        check("R2", {ctx, " adv_sts"}, 64'(adv_sts), 64'(m_adv));
        check("R3", {ctx, " unc_sts"}, 64'(unc_sts), 64'(m_unc));
        check("R4", {ctx, " ptr_vld"}, 64'(first_ptr_vld), 64'(m_vld));
        check("R4", {ctx, " ptr"}, 64'(first_ptr), 64'(m_ptr));
        check("R4", {ctx, " hdr_log"}, 64'(hdr_log), 64'(m_hdr));
        check("R5", {ctx, " msg_req"}, 64'(cor_msg_req), 64'(m_req));
    endtask

    // One cycle: drive the inputs, predict the result, check it after the edge.
    task automatic step(string ctx, logic ev, logic [2:0] t, logic [HW-1:0] h,
                        logic [NT-1:0] sev, logic [NT-1:0] um, logic am, logic en,
                        logic [NT-1:0] cu, logic ca, logic cc);
        logic          inr, nf, su, lg, rel;
        logic [NT-1:0] oh, poh;
        evt_valid = ev; evt_type = t; evt_hdr = h;
        cfg_sev_fatal = sev; cfg_unc_mask = um; cfg_adv_mask = am; cfg_cor_msg_en = en;
        clr_unc_sts = cu; clr_adv_sts = ca; clr_cor_det = cc;
        inr = (t < 3'(NT));
        oh  = inr ? (NT'(1) << t) : '0;
        poh = NT'(1) << m_ptr;
        nf  = ev && inr && !(|(sev & oh));
        su  = nf && !am;
        lg  = su && !(|(um & oh)) && !m_vld;
        rel = m_vld && |(poh & cu & ~(su ? oh : '0));
        @(posedge clk);
        m_cor = nf | (m_cor & ~cc);
        m_adv = nf | (m_adv & ~ca);
        m_unc = (su ? oh : '0) | (m_unc & ~cu);
        m_req = su && en;
        if (lg) begin m_vld = 1'b1; m_ptr = t; m_hdr = h; end
        else if (rel) m_vld = 1'b0;
        @(negedge clk);
        check_all(ctx);
        evt_valid = 1'b0; clr_unc_sts = '0; clr_adv_sts = 1'b0; clr_cor_det = 1'b0;
    endtask

    task automatic clear_all();
        step("R7 clear", 1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0, '1, 1'b1, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_cor = 0; m_adv = 0; m_vld = 0; m_req = 0; m_unc = '0; m_ptr = '0; m_hdr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1 reset");

        // R5: back-to-back qualifying events give back-to-back pulses.
        for (int k = 0; k < 3; k++)
            step("R5 b2b", 1'b1, 3'(k), 32'hA000 + 32'(k), '0, '0, 1'b0, 1'b1, '0, 1'b0, 1'b0);
        step("R5 idle", 1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b1, '0, 1'b0, 1'b0);
        check("R5", "pulse ended", 64'(cor_msg_req), 64'd0);
        check("R4", "first of burst", 64'(first_ptr), 64'd0);

        // R8: clearing a bit the pointer does not name keeps the flag; clearing the named bit releases it.
        step("R8 other", 1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0, 5'b00010, 1'b0, 1'b0);
        check("R8", "vld kept", 64'(first_ptr_vld), 64'd1);
        step("R8 own", 1'b0, 3'd0, '0, '0, '0, 1'b0, 1'b0, 5'b00001, 1'b0, 1'b0);
        check("R8", "vld released", 64'(first_ptr_vld), 64'd0);
        step("R8 relog", 1'b1, 3'd3, 32'hBEEF, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        check("R8", "relogged hdr", 64'(hdr_log), 64'hBEEF);

        // R9: a set and a clear of the same bit in one cycle leave it set, and the flag held.
        step("R9 collide", 1'b1, 3'd3, 32'h1, '0, '0, 1'b0, 1'b0, 5'b01000, 1'b1, 1'b1);
        check("R9", "bit 3 kept", 64'(unc_sts[3]), 64'd1);
        check("R9", "vld kept", 64'(first_ptr_vld), 64'd1);

        // R10: an out-of-range index does nothing.
        clear_all();
        step("R10 range", 1'b1, 3'd6, 32'h77, '0, '0, 1'b0, 1'b1, '0, 1'b0, 1'b0);
        check("R10", "cor_det", 64'(cor_det), 64'd0);

        // Sweep: every index, every configuration, pointer free or held (R2 R3 R4 R6).
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < 16; c++) begin
                for (int pv = 0; pv < 2; pv++) begin
                    clear_all();
                    if (pv == 1)
                        step("R4 prime", 1'b1, 3'((t + 1) % NT), 32'h5A5A0000 + 32'(t),
                             '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
                    step(c[0] ? "R6 sweep" : "R2 sweep", 1'b1, 3'(t), 32'hC0DE0000 + 32'(t * 64 + c),
                         c[0] ? 5'b11111 : 5'b00000, c[1] ? 5'b11111 : 5'b00000,
                         c[2], c[3], '0, 1'b0, 1'b0);
                end
            end
        end

        // Random events and clears (R7 R9 R8).
        for (int i = 0; i < 3000; i++) begin
            step("R7 rand", ($urandom % 3) != 0, 3'($urandom % 8), $urandom,
                 5'($urandom), 5'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 0,
                 ($urandom % 4) == 0 ? 5'($urandom) : 5'd0,
                 ($urandom % 6) == 0, ($urandom % 6) == 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule